// File: doc/BRIEF.md
# Power-Saving Mode Clock Controller

This block sequences a microcontroller between three operating states: full run, a light sleep in which only the processor clock is halted, and a deep stop in which the main oscillator and every clock derived from it are shut down while the low-speed sub oscillator keeps running. The processor raises a one-cycle sleep or stop request. The block answers with registered enables for the oscillators, for the processor, system and peripheral clocks, and for the run state of the individual peripherals. It also drives the signals that force the crystal pins low.

Wake-up depends on the state. From sleep, any interrupt line that is both pending and enabled returns the device to run. From stop, only the enabled lines named in a parameter mask can wake it: by default key scan, serial port, watch timer, timer/event counter and the external pin. Any other line is ignored. Leaving stop does not restart the clocks at once. The main oscillator is switched back on first, and a settling counter, decremented by a strobe from the sub-clock domain, must reach zero before run resumes. A two-bit clock-source select lets software park the main oscillator while the device runs or sleeps on the sub clock.

Top module: `pwr_clk_ctrl`

## Requirements
- R1: While `rst` is high and on the first edge after it, `mode` is 0 (run), every clock and run enable is 1 (main oscillator included), and both pin-low controls are 0.
- R2: In run, `stop_req` enters stop (mode 2) on the next edge; when `stop_req` and `sleep_req` are high together, stop wins.
- R3: In run, `sleep_req` alone enters sleep (mode 1); in sleep `cpu_clk_en` is 0 while the system and peripheral clocks and the interval timer enable stay 1.
- R4: In sleep, the next edge returns to run if `irq & irq_en` is non-zero; pending lines whose enable bit is 0 have no effect.
- R5: In stop, `main_osc_en`, `cpu_clk_en`, `sys_clk_en`, `peri_clk_en` and `bit_run` are 0, and `xin_low` and `xout_low` are 1.
- R6: In stop, only enabled lines selected by the wake mask cause a wake. With the default mask these are bits 0 to 4 (key scan, serial, watch timer, timer/event, external). Bits 5 to 7 leave the block in stop.
- R7: A stop wake enters settling (mode 3) and loads `stab_cnt`. Each `sub_tick` in settling decrements the count. The first edge at which the count is zero returns to run, so `stab_cnt` = 0 gives one settling cycle. During settling `main_osc_en` is 1, the pins are released, and the processor, system and peripheral clocks stay 0.
- R8: `tmr_run` is 1 in run and sleep; in stop and settling it equals `evt_mode`.
- R9: `sub_osc_en`, `wt_run` and `key_run` are 1 in every mode.
- R10: In run and sleep, `main_osc_en` is 0 when `clk_sel` is 3 and 1 for values 0, 1 and 2.
- R11: The `mode` encoding is 0 run, 1 sleep, 2 stop and 3 settling. All outputs are registered and update on the same edge as `mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_req | input | 1 | Request to halt the processor clock |
| stop_req | input | 1 | Request to enter deep stop |
| clk_sel | input | 2 | Clock-source select; 3 parks the main oscillator |
| evt_mode | input | 1 | Timer/event counter is in event-counting mode |
| irq | input | NUM_IRQ | Pending interrupt lines |
| irq_en | input | NUM_IRQ | Per-line interrupt enables |
| sub_tick | input | 1 | One-cycle strobe per sub-clock period |
| stab_cnt | input | STAB_W | Settling length in sub-clock ticks |
| mode | output | 2 | Current state |
| main_osc_en | output | 1 | Main oscillator enable |
| sub_osc_en | output | 1 | Sub oscillator enable |
| cpu_clk_en | output | 1 | Processor clock enable |
| sys_clk_en | output | 1 | System clock enable |
| peri_clk_en | output | 1 | Peripheral clock enable |
| bit_run | output | 1 | Basic interval timer run enable |
| tmr_run | output | 1 | Timer/event counter run enable |
| wt_run | output | 1 | Watch timer run enable |
| key_run | output | 1 | Key scan run enable |
| xin_low | output | 1 | Force crystal input pin low |
| xout_low | output | 1 | Force crystal output pin low |

## Verification
Every output is due exactly one edge after the inputs that cause it. A request or a wake line presented before edge N shows up in `mode` and in every enable after edge N. The bench drives inputs on the falling edge. A behavioural model advances on each rising edge from the same inputs, and all outputs are compared on the following falling edge, so no check lands in the cycle where a register is changing. For settling, the model keeps its own integer count of `sub_tick` strobes. The return to run is expected one edge after that count reaches zero, and directed checks confirm the mode both partway through settling and after it ends.

// File: rtl/pcc_pkg.sv
package pcc_pkg;

  typedef enum logic [1:0] {
    PM_RUN   = 2'd0,
    PM_SLEEP = 2'd1,
    PM_STOP  = 2'd2,
    PM_STAB  = 2'd3
  } pm_mode_t;

  typedef struct packed {
    logic main_osc;
    logic sub_osc;
    logic cpu_clk;
    logic sys_clk;
    logic peri_clk;
    logic bit_run;
    logic tmr_run;
    logic wt_run;
    logic key_run;
    logic xin_low;
    logic xout_low;
  } pcc_en_t;

  localparam logic [1:0] CLK_SEL_SUB_ONLY = 2'b11;

endpackage

// File: rtl/pcc_wake.sv
module pcc_wake #(
  parameter int unsigned          NUM_IRQ        = 8,
  parameter logic [NUM_IRQ-1:0]   STOP_WAKE_MASK = NUM_IRQ'(5'h1F)
) (
  input  logic [NUM_IRQ-1:0] irq,
  input  logic [NUM_IRQ-1:0] irq_en,
  output logic               any_wake,
  output logic               stop_wake
);

  logic [NUM_IRQ-1:0] live;
  logic [NUM_IRQ-1:0] stop_live;

  // per-line qualification; the stop set is fixed by the mask parameter
  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
    assign live[i] = irq[i] & irq_en[i];
    if (STOP_WAKE_MASK[i]) begin : g_stop_src
      assign stop_live[i] = live[i];
    end else begin : g_stop_blocked
      assign stop_live[i] = 1'b0;
    end
  end

  assign any_wake  = |live;
  assign stop_wake = |stop_live;

  // R6: a stop-capable wake is always also a general wake
  always_comb begin
    a_r6_stop_subset: assert (!stop_wake || any_wake);
  end

endmodule

// File: rtl/pcc_stab_cnt.sv
module pcc_stab_cnt #(
  parameter int unsigned STAB_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [STAB_W-1:0] load_val,
  input  logic              run,
  input  logic              tick,
  output logic              done
);

  logic [STAB_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (run && tick && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = (cnt_q == '0);

  // R7: each tick during settling removes exactly one count
  a_r7_count_down: assert property (@(posedge clk) disable iff (rst)
    (!load && run && tick && !done) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R7: without a tick the count holds
  a_r7_count_hold: assert property (@(posedge clk) disable iff (rst)
    (!load && !tick) |=> $stable(cnt_q));

endmodule

// File: rtl/pcc_mode_fsm.sv
module pcc_mode_fsm
  import pcc_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     sleep_req,
  input  logic     stop_req,
  input  logic     any_wake,
  input  logic     stop_wake,
  input  logic     stab_done,
  output pm_mode_t mode_q,
  output pm_mode_t mode_d,
  output logic     load_stab
);

  always_comb begin
    mode_d    = mode_q;
    load_stab = 1'b0;
    unique case (mode_q)
      PM_RUN: begin
        if (stop_req)       mode_d = PM_STOP;
        else if (sleep_req) mode_d = PM_SLEEP;
      end
      PM_SLEEP: begin
        if (any_wake) mode_d = PM_RUN;
      end
      PM_STOP: begin
        if (stop_wake) begin
          mode_d    = PM_STAB;
          load_stab = 1'b1;
        end
      end
      PM_STAB: begin
        if (stab_done) mode_d = PM_RUN;
      end
      default: mode_d = PM_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) mode_q <= PM_RUN;
    else     mode_q <= mode_d;
  end

  a_r2_stop_wins: assert property (@(posedge clk) disable iff (rst)
    (mode_q == PM_RUN && stop_req) |=> (mode_q == PM_STOP));

  a_r6_stop_holds: assert property (@(posedge clk) disable iff (rst)
    (mode_q == PM_STOP && !stop_wake) |=> (mode_q == PM_STOP));

  a_r7_stab_waits: assert property (@(posedge clk) disable iff (rst)
    (mode_q == PM_STAB && !stab_done) |=> (mode_q == PM_STAB));

  a_r4_sleep_exit: assert property (@(posedge clk) disable iff (rst)
    (mode_q == PM_SLEEP && any_wake) |=> (mode_q == PM_RUN));

endmodule

// File: rtl/pcc_out_reg.sv
module pcc_out_reg
  import pcc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  pm_mode_t   mode_d,
  input  logic [1:0] clk_sel,
  input  logic       evt_mode,
  output pcc_en_t    en_q
);

  pcc_en_t en_d;
  logic    main_wanted;

  assign main_wanted = (clk_sel != CLK_SEL_SUB_ONLY);

  always_comb begin
    en_d          = '0;
    en_d.sub_osc  = 1'b1;
    en_d.wt_run   = 1'b1;
    en_d.key_run  = 1'b1;
    unique case (mode_d)
      PM_RUN, PM_SLEEP: begin
        en_d.main_osc = main_wanted;
        en_d.cpu_clk  = (mode_d == PM_RUN);
        en_d.sys_clk  = 1'b1;
        en_d.peri_clk = 1'b1;
        en_d.bit_run  = 1'b1;
        en_d.tmr_run  = 1'b1;
      end
      PM_STOP: begin
        en_d.tmr_run  = evt_mode;
        en_d.xin_low  = 1'b1;
        en_d.xout_low = 1'b1;
      end
      PM_STAB: begin
        en_d.main_osc = 1'b1;
        en_d.tmr_run  = evt_mode;
      end
      default: en_d.main_osc = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q          <= '0;
      en_q.main_osc <= 1'b1;
      en_q.sub_osc  <= 1'b1;
      en_q.cpu_clk  <= 1'b1;
      en_q.sys_clk  <= 1'b1;
      en_q.peri_clk <= 1'b1;
      en_q.bit_run  <= 1'b1;
      en_q.tmr_run  <= 1'b1;
      en_q.wt_run   <= 1'b1;
      en_q.key_run  <= 1'b1;
    end else begin
      en_q <= en_d;
    end
  end

  // R10: a parked main oscillator follows the select on the next edge
  a_r10_park_main: assert property (@(posedge clk) disable iff (rst)
    ((mode_d == PM_RUN || mode_d == PM_SLEEP) && clk_sel == CLK_SEL_SUB_ONLY)
      |=> !en_q.main_osc);

endmodule

// File: rtl/pwr_clk_ctrl.sv
module pwr_clk_ctrl
  import pcc_pkg::*;
#(
  parameter int unsigned        NUM_IRQ        = 8,
  parameter logic [NUM_IRQ-1:0] STOP_WAKE_MASK = NUM_IRQ'(5'h1F),
  parameter int unsigned        STAB_W         = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sleep_req,
  input  logic               stop_req,
  input  logic [1:0]         clk_sel,
  input  logic               evt_mode,
  input  logic [NUM_IRQ-1:0] irq,
  input  logic [NUM_IRQ-1:0] irq_en,
  input  logic               sub_tick,
  input  logic [STAB_W-1:0]  stab_cnt,
  output logic [1:0]         mode,
  output logic               main_osc_en,
  output logic               sub_osc_en,
  output logic               cpu_clk_en,
  output logic               sys_clk_en,
  output logic               peri_clk_en,
  output logic               bit_run,
  output logic               tmr_run,
  output logic               wt_run,
  output logic               key_run,
  output logic               xin_low,
  output logic               xout_low
);

  logic     any_wake;
  logic     stop_wake;
  logic     stab_done;
  logic     load_stab;
  pm_mode_t mode_q;
  pm_mode_t mode_d;
  pcc_en_t  en_q;

  pcc_wake #(
    .NUM_IRQ        (NUM_IRQ),
    .STOP_WAKE_MASK (STOP_WAKE_MASK)
  ) u_wake (
    .irq       (irq),
    .irq_en    (irq_en),
    .any_wake  (any_wake),
    .stop_wake (stop_wake)
  );

  pcc_stab_cnt #(
    .STAB_W (STAB_W)
  ) u_stab (
    .clk      (clk),
    .rst      (rst),
    .load     (load_stab),
    .load_val (stab_cnt),
    .run      (mode_q == PM_STAB),
    .tick     (sub_tick),
    .done     (stab_done)
  );

  pcc_mode_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .sleep_req (sleep_req),
    .stop_req  (stop_req),
    .any_wake  (any_wake),
    .stop_wake (stop_wake),
    .stab_done (stab_done),
    .mode_q    (mode_q),
    .mode_d    (mode_d),
    .load_stab (load_stab)
  );

  pcc_out_reg u_out (
    .clk      (clk),
    .rst      (rst),
    .mode_d   (mode_d),
    .clk_sel  (clk_sel),
    .evt_mode (evt_mode),
    .en_q     (en_q)
  );

  assign mode        = mode_q;
  assign main_osc_en = en_q.main_osc;
  assign sub_osc_en  = en_q.sub_osc;
  assign cpu_clk_en  = en_q.cpu_clk;
  assign sys_clk_en  = en_q.sys_clk;
  assign peri_clk_en = en_q.peri_clk;
  assign bit_run     = en_q.bit_run;
  assign tmr_run     = en_q.tmr_run;
  assign wt_run      = en_q.wt_run;
  assign key_run     = en_q.key_run;
  assign xin_low     = en_q.xin_low;
  assign xout_low    = en_q.xout_low;

  a_r5_stop_gated: assert property (@(posedge clk) disable iff (rst)
    (mode_q == PM_STOP) |-> (!main_osc_en && !sys_clk_en && !peri_clk_en
                             && !cpu_clk_en && !bit_run && xin_low && xout_low));

  a_r3_sleep_cpu_only: assert property (@(posedge clk) disable iff (rst)
    (mode_q == PM_SLEEP) |-> (!cpu_clk_en && sys_clk_en && peri_clk_en && bit_run));

  a_r9_always_on: assert property (@(posedge clk) disable iff (rst)
    sub_osc_en && wt_run && key_run);

  a_r7_stab_clocks: assert property (@(posedge clk) disable iff (rst)
    (mode_q == PM_STAB) |-> (main_osc_en && !xin_low && !sys_clk_en && !cpu_clk_en));

  a_r8_timer_stop: assert property (@(posedge clk) disable iff (rst)
    (mode_q == PM_STOP) |-> (tmr_run == $past(evt_mode)));

endmodule

// File: tb/pwr_clk_ctrl_bench.sv
module pwr_clk_ctrl_bench;

  localparam int CYC = 20;

  logic       clk = 1'b0;
  logic       rst;
  logic       sleep_req, stop_req, evt_mode, sub_tick;
  logic [1:0] clk_sel;
  logic [7:0] irq, irq_en, stab_cnt;
  logic [1:0] mode;
  logic main_osc_en, sub_osc_en, cpu_clk_en, sys_clk_en, peri_clk_en;
  logic bit_run, tmr_run, wt_run, key_run, xin_low, xout_low;

  int vec_cnt  = 0;
  int miss_cnt = 0;
  int tcnt     = 0;
  bit model_ok = 1'b0;

  // behavioural reference state
  int   m_mode, m_cnt;
  logic e_main, e_cpu, e_sys, e_peri, e_bit, e_tmr, e_pin;

  always #(CYC/2) clk = ~clk;

  pwr_clk_ctrl u_pwr_clk_ctrl (
    .clk(clk), .rst(rst), .sleep_req(sleep_req), .stop_req(stop_req),
    .clk_sel(clk_sel), .evt_mode(evt_mode), .irq(irq), .irq_en(irq_en),
    .sub_tick(sub_tick), .stab_cnt(stab_cnt), .mode(mode),
    .main_osc_en(main_osc_en), .sub_osc_en(sub_osc_en), .cpu_clk_en(cpu_clk_en),
    .sys_clk_en(sys_clk_en), .peri_clk_en(peri_clk_en), .bit_run(bit_run),
    .tmr_run(tmr_run), .wt_run(wt_run), .key_run(key_run),
    .xin_low(xin_low), .xout_low(xout_low)
  );

  task automatic chk(input string tag, input int act, input int exp);
    vec_cnt++;
    if (act != exp) begin
      miss_cnt++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model: advances on the same edge as the design
  always @(posedge clk) begin
    int nm, nc;
    if (rst) begin
      m_mode = 0; m_cnt = 0;
      e_main = 1; e_cpu = 1; e_sys = 1; e_peri = 1; e_bit = 1; e_tmr = 1; e_pin = 0;
    end else begin
      nm = m_mode; nc = m_cnt;
      case (m_mode)
        0: if (stop_req) nm = 2; else if (sleep_req) nm = 1;
        1: if ((irq & irq_en) != 0) nm = 0;
        2: if ((irq & irq_en & 8'h1F) != 0) begin nm = 3; nc = stab_cnt; end
        default: if (m_cnt == 0) nm = 0; else if (sub_tick) nc = m_cnt - 1;
      endcase
      m_mode = nm; m_cnt = nc;
      e_pin  = (nm == 2);
      e_main = (nm <= 1) ? (clk_sel != 2'b11) : (nm == 3);
      e_cpu  = (nm == 0);
      e_sys  = (nm <= 1);
      e_peri = (nm <= 1);
      e_bit  = (nm <= 1);
      e_tmr  = (nm <= 1) ? 1'b1 : evt_mode;
    end
    model_ok = 1'b1;
  end

  // compare every output on the falling edge
  always @(negedge clk) begin
    if (model_ok) begin
      chk("R11 mode",        mode,        m_mode);
      chk("R10 main_osc_en", main_osc_en, e_main);
      chk("R3 cpu_clk_en",   cpu_clk_en,  e_cpu);
      chk("R5 sys_clk_en",   sys_clk_en,  e_sys);
      chk("R5 peri_clk_en",  peri_clk_en, e_peri);
      chk("R5 bit_run",      bit_run,     e_bit);
      chk("R8 tmr_run",      tmr_run,     e_tmr);
      chk("R5 xin_low",      xin_low,     e_pin);
      chk("R5 xout_low",     xout_low,    e_pin);
      chk("R9 sub_osc_en",   sub_osc_en,  1);
      chk("R9 wt_run",       wt_run,      1);
      chk("R9 key_run",      key_run,     1);
    end
  end

  // advance n cycles; sub_tick strobes once every four cycles
  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      sub_tick = (tcnt % 4 == 3);
      tcnt++;
      @(negedge clk);
    end
    sub_tick = 1'b0;
  endtask

  initial begin
    #(CYC * 200000);
    miss_cnt++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, miss_cnt);
    $finish;
  end

  initial begin
    rst = 1; sleep_req = 0; stop_req = 0; evt_mode = 0; sub_tick = 0;
    clk_sel = 2'b00; irq = 0; irq_en = 0; stab_cnt = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset mode", mode, 0);
    chk("R1 reset main", main_osc_en, 1);
    chk("R1 reset pins", xin_low, 0);
    rst = 0;
    run(2);
    chk("R1 run after reset", mode, 0);

    // R10: select 3 parks main oscillator; other values keep it running
    clk_sel = 2'b11; run(1);
    chk("R10 parked", main_osc_en, 0);
    clk_sel = 2'b10; run(1);
    chk("R10 select 2", main_osc_en, 1);
    clk_sel = 2'b00;

    // R3 / R4: sleep, masked line ignored, enabled line wakes
    sleep_req = 1; run(1); sleep_req = 0;
    chk("R3 sleep entry", mode, 1);
    clk_sel = 2'b11; run(1);
    chk("R10 sleep parked", main_osc_en, 0);
    clk_sel = 2'b01;
    irq = 8'h80; irq_en = 8'h7F; run(2);
    chk("R4 disabled line", mode, 1);
    irq_en = 8'hFF; run(1);
    chk("R4 wake", mode, 0);
    irq = 0; run(1);

    // R2: both requests, stop wins
    evt_mode = 1;
    stop_req = 1; sleep_req = 1; run(1); stop_req = 0; sleep_req = 0;
    chk("R2 stop priority", mode, 2);
    chk("R8 event mode", tmr_run, 1);
    evt_mode = 0; run(1);
    chk("R8 timer halted", tmr_run, 0);

    // R6: lines outside the stop set are ignored
    irq = 8'hE0; run(3);
    chk("R6 masked sources", mode, 2);
    irq = 8'h04; irq_en = 8'hFB; run(1);
    chk("R6 disabled watch", mode, 2);

    // R7: watch timer wake with a settling count of 3
    stab_cnt = 8'd3; irq_en = 8'hFF; run(1); irq = 0;
    chk("R7 settle entry", mode, 3);
    chk("R7 main on", main_osc_en, 1);
    run(2);
    chk("R7 still settling", mode, 3);
    run(20);
    chk("R7 back to run", mode, 0);

    // R7: zero count gives one settling cycle
    stab_cnt = 8'd0;
    stop_req = 1; run(1); stop_req = 0;
    irq = 8'h01; run(1); irq = 0;
    chk("R7 zero settle", mode, 3);
    run(1);
    chk("R7 zero exit", mode, 0);

    // longer count with event mode held
    evt_mode = 1; stab_cnt = 8'd9;
    stop_req = 1; run(1); stop_req = 0;
    irq = 8'h10; run(1); irq = 0;
    run(45);
    chk("R7 long settle done", mode, 0);

    // reset from deep stop returns to run
    stop_req = 1; run(1); stop_req = 0;
    rst = 1; run(2);
    chk("R1 reset from stop", mode, 0);
    rst = 0; run(3);

    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, miss_cnt);
    $finish;
  end

endmodule